// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel buses, called A and B, through a pair of storage registers, one per side, each on its own clock. An active-low output enable and a direction input decide which of the two buses the block drives. For each direction, a select input picks what goes out on the driven bus: either the live value arriving on the other bus, passed straight through, or the value held in the register on the other side.

Each bus is modelled as three separate vectors: an input, an output and an output enable. A pad wrapper, or a resolver in a bench, can then form the real tri-state bus, while the block itself stays synthesizable. The registers keep capturing on every edge of their clocks, whether the outputs are enabled or isolated. Software-free control comes entirely from the four select and enable pins.

Top module: `bidir_store_xcvr`

## Requirements
- R1: On every rising edge of `clk_a` with `rst` low, the A-side register loads `a_in`, whatever `oe_n`, `dir_a2b` and the selects are.
- R2: On every rising edge of `clk_b` with `rst` low, the B-side register loads `b_in`, whatever `oe_n`, `dir_a2b` and the selects are.
- R3: A rising edge of a side's clock with `rst` high clears that side's register to all zeros (synchronous, active high).
- R4: With `oe_n` high (isolation), `a_oe`, `b_oe`, `a_out` and `b_out` are all zeros.
- R5: With `oe_n` low and `dir_a2b` high, `b_oe` is all ones and `a_oe` is all zeros.
- R6: With `oe_n` low and `dir_a2b` low, `a_oe` is all ones and `b_oe` is all zeros.
- R7: While driving B, `sel_a2b` low makes `b_out` equal `a_in` combinationally, with no clock latency.
- R8: While driving B, `sel_a2b` high makes `b_out` equal the A-side register.
- R9: While driving A, `sel_b2a` low makes `a_out` equal `b_in` combinationally.
- R10: While driving A, `sel_b2a` high makes `a_out` equal the B-side register.
- R11: In stored mode, data captured by a source-side clock edge appears on the driven bus right after that same edge.
- R12: The output vector of the bus that is not driven reads all zeros, and the two enable vectors are never non-zero together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Capture clock of the A-side register |
| clk_b | input | 1 | Capture clock of the B-side register |
| rst | input | 1 | Synchronous active-high reset of both registers |
| oe_n | input | 1 | Active-low output enable; high isolates both buses |
| dir_a2b | input | 1 | High: drive B from the A side; low: drive A from the B side |
| sel_a2b | input | 1 | B-bound source: 0 live A bus, 1 A-side register |
| sel_b2a | input | 1 | A-bound source: 0 live B bus, 1 B-side register |
| a_in | input | W | Value seen on bus A |
| a_out | output | W | Value to drive on bus A |
| a_oe | output | W | Per-bit drive enable for bus A |
| b_in | input | W | Value seen on bus B |
| b_out | output | W | Value to drive on bus B |
| b_oe | output | W | Per-bit drive enable for bus B |

## Verification
On every clock edge the embedded properties confirm that each register holds the bus value present at its previous edge, that isolation clears both enables, that the two enables never overlap, and that the driven output matches the live or stored source chosen by the select. What those samples cannot show is the combinational nature of the transparent paths between edges, the reset clearing seen at the ports, and stored data appearing right after its own capture edge. The bench shows these by sweeping all sixteen combinations of enable, direction and both selects, with several data patterns and clock pulses on each side, against an arithmetic reference model.

// File: rtl/bidir_store_xcvr_pkg.sv
package bidir_store_xcvr_pkg;

  typedef enum logic [1:0] {
    XFER_ISOLATE = 2'd0,
    XFER_TO_B    = 2'd1,
    XFER_TO_A    = 2'd2
  } xfer_e;

  // Map enable and direction pins onto the transfer state.
  function automatic xfer_e xfer_decode(input logic oe_n, input logic dir_a2b);
    if (oe_n)        return XFER_ISOLATE;
    else if (dir_a2b) return XFER_TO_B;
    else             return XFER_TO_A;
  endfunction

endpackage

// File: rtl/side_store.sv
module side_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  // R1 R2
  capture_always_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (q == $past(d)));

endmodule

// File: rtl/drive_ctrl.sv
module drive_ctrl
  import bidir_store_xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir_a2b,
  output logic         drive_a,
  output logic         drive_b,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_oe
);

  xfer_e xfer;

  always_comb begin
    xfer    = xfer_decode(oe_n, dir_a2b);
    drive_a = (xfer == XFER_TO_A);
    drive_b = (xfer == XFER_TO_B);
    a_oe    = {W{drive_a}};
    b_oe    = {W{drive_b}};
  end

  // R4
  isolate_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (a_oe == '0 && b_oe == '0));

  // R12
  no_double_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !((|a_oe) && (|b_oe)));

  // R5
  drive_b_full_chk: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && dir_a2b) |-> (b_oe == '1));

  // R6
  drive_a_full_chk: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !dir_a2b) |-> (a_oe == '1));

endmodule

// File: rtl/path_mux.sv
module path_mux #(
  parameter int W = 8
) (
  input  logic         drive,
  input  logic         use_store,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] y
);

  // Source pick gated by the drive qualifier; undriven side reads zero.
  function automatic logic [W-1:0] pick(input logic en, input logic s,
                                        input logic [W-1:0] l,
                                        input logic [W-1:0] r);
    if (!en) return '0;
    return s ? r : l;
  endfunction

  assign y = pick(drive, use_store, live, stored);

endmodule

// File: rtl/bidir_store_xcvr.sv
module bidir_store_xcvr #(
  parameter int W = 8
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir_a2b,
  input  logic         sel_a2b,
  input  logic         sel_b2a,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);

  logic [W-1:0] a_store;
  logic [W-1:0] b_store;
  logic         drive_a;
  logic         drive_b;

  side_store #(.W(W)) u_store_a (
    .clk(clk_a), .rst(rst), .d(a_in), .q(a_store)
  );

  side_store #(.W(W)) u_store_b (
    .clk(clk_b), .rst(rst), .d(b_in), .q(b_store)
  );

  drive_ctrl #(.W(W)) u_ctrl (
    .clk(clk_a), .rst(rst), .oe_n(oe_n), .dir_a2b(dir_a2b),
    .drive_a(drive_a), .drive_b(drive_b), .a_oe(a_oe), .b_oe(b_oe)
  );

  path_mux #(.W(W)) u_to_b (
    .drive(drive_b), .use_store(sel_a2b), .live(a_in), .stored(a_store), .y(b_out)
  );

  path_mux #(.W(W)) u_to_a (
    .drive(drive_a), .use_store(sel_b2a), .live(b_in), .stored(b_store), .y(a_out)
  );

  // R7
  b_live_chk: assert property (@(posedge clk_b) disable iff (rst)
    (!oe_n && dir_a2b && !sel_a2b) |-> (b_out == a_in));

  // R8
  b_stored_chk: assert property (@(posedge clk_b) disable iff (rst)
    (!oe_n && dir_a2b && sel_a2b) |-> (b_out == a_store));

  // R9
  a_live_chk: assert property (@(posedge clk_a) disable iff (rst)
    (!oe_n && !dir_a2b && !sel_b2a) |-> (a_out == b_in));

  // R10
  a_stored_chk: assert property (@(posedge clk_a) disable iff (rst)
    (!oe_n && !dir_a2b && sel_b2a) |-> (a_out == b_store));

  // R12
  a_idle_zero_chk: assert property (@(posedge clk_a) disable iff (rst)
    (a_oe == '0) |-> (a_out == '0));

endmodule

// File: tb/tb_bidir_store_xcvr.sv
module tb_bidir_store_xcvr;
  localparam int W = 8;

  logic clk_a = 0, clk_b = 0, rst = 1;
  logic oe_n = 1, dir_a2b = 0, sel_a2b = 0, sel_b2a = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  logic [W-1:0] ref_a, ref_b;
  int compared = 0, mismatched = 0;
  bit done = 0;

  bidir_store_xcvr #(.W(W)) dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .oe_n(oe_n), .dir_a2b(dir_a2b),
    .sel_a2b(sel_a2b), .sel_b2a(sel_b2a), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic cmp(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // 250 MHz: 4 ns per pulse
  task automatic pulse_a();
    clk_a = 1;
    ref_a = rst ? '0 : a_in;
    #2 clk_a = 0;
    #2;
  endtask

  task automatic pulse_b();
    clk_b = 1;
    ref_b = rst ? '0 : b_in;
    #2 clk_b = 0;
    #2;
  endtask

  // Full reference comparison of all four outputs.
  task automatic check_all();
    logic [W-1:0] e_aoe, e_boe, e_aout, e_bout;
    string t_oe_a, t_oe_b, t_a, t_b;
    e_aoe = (!oe_n && !dir_a2b) ? '1 : '0;
    e_boe = (!oe_n &&  dir_a2b) ? '1 : '0;
    e_bout = (e_boe == '0) ? '0 : (sel_a2b ? ref_a : a_in);
    e_aout = (e_aoe == '0) ? '0 : (sel_b2a ? ref_b : b_in);
    t_oe_a = oe_n ? "R4" : (dir_a2b ? "R5" : "R6");
    t_oe_b = oe_n ? "R4" : (dir_a2b ? "R5" : "R6");
    t_b = oe_n ? "R4" : (!dir_a2b ? "R12" : (sel_a2b ? "R8" : "R7"));
    t_a = oe_n ? "R4" : ( dir_a2b ? "R12" : (sel_b2a ? "R10" : "R9"));
    #1;
    cmp(t_oe_a, "a_oe", a_oe, e_aoe);
    cmp(t_oe_b, "b_oe", b_oe, e_boe);
    cmp(t_a, "a_out", a_out, e_aout);
    cmp(t_b, "b_out", b_out, e_bout);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    ref_a = '0; ref_b = '0;
    a_in = 8'hC3; b_in = 8'h3C;
    #1;
    pulse_a(); pulse_b();
    rst = 0;
    // R3: reset state seen through stored mode
    oe_n = 0; dir_a2b = 1; sel_a2b = 1; #1;
    cmp("R3", "b_out after reset", b_out, '0);
    dir_a2b = 0; sel_b2a = 1; #1;
    cmp("R3", "a_out after reset", a_out, '0);

    // R1 R2: capture while isolated, then reveal
    oe_n = 1; a_in = 8'h5A; b_in = 8'hA5; #1;
    pulse_a(); pulse_b();
    a_in = 8'h00; b_in = 8'hFF;
    oe_n = 0; dir_a2b = 1; sel_a2b = 1; #1;
    cmp("R1", "b_out shows A capture made while isolated", b_out, 8'h5A);
    dir_a2b = 0; sel_b2a = 1; #1;
    cmp("R2", "a_out shows B capture made while isolated", a_out, 8'hA5);

    // R11: stored data appears right after its own capture edge
    dir_a2b = 1; sel_a2b = 1; a_in = 8'h96; #1;
    clk_a = 1; ref_a = a_in; #1;
    cmp("R11", "b_out after A edge", b_out, 8'h96);
    #1 clk_a = 0; #2;
    dir_a2b = 0; sel_b2a = 1; b_in = 8'h69; #1;
    clk_b = 1; ref_b = b_in; #1;
    cmp("R11", "a_out after B edge", a_out, 8'h69);
    #1 clk_b = 0; #2;

    // Sweep all 16 control combinations with several data patterns.
    for (int c = 0; c < 16; c++) begin
      {oe_n, dir_a2b, sel_a2b, sel_b2a} = 4'(c);
      for (int k = 0; k < 4; k++) begin
        a_in = 8'(c * 37 + k * 91 + 5);
        b_in = ~a_in ^ 8'h5A;
        check_all();
        pulse_a();
        check_all();
        a_in = a_in + 8'd17;   // R7 R9: live change with no edge
        check_all();
        pulse_b();
        check_all();
        b_in = b_in ^ 8'h81;
        check_all();
      end
    end

    // R3: mid-run reset clears both registers
    a_in = 8'hEE; b_in = 8'h77;
    pulse_a(); pulse_b();
    rst = 1; pulse_a(); pulse_b(); rst = 0;
    oe_n = 0; dir_a2b = 1; sel_a2b = 1; #1;
    cmp("R3", "b_out after mid-run reset", b_out, '0);
    dir_a2b = 0; sel_b2a = 1; #1;
    cmp("R3", "a_out after mid-run reset", a_out, '0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule